// File: doc/BRIEF.md
# Extended Mode Register Command Decoder

This block sits on the device side of a DDR SDRAM command bus. It samples the chip-select and row/column/write strobes on every rising clock edge. It picks out writes to the extended mode register, and from each accepted write it keeps two settings: whether the DLL is enabled, and which output drive strength is selected. The settings are exposed as plain outputs that the DLL and the output driver logic use. A valid flag stays low until the first accepted write, because the register has no defined value at power-up. Until then, the DLL and drive-strength outputs carry no meaning.

The block does not store a write that breaks the rules. This covers CKE low, a bank that is not idle, a reserved bit that is nonzero, a drive code that may not be used, and a command that arrives while the previous write is still completing. Each kind of violation sets its own sticky error flag. A busy flag covers the two-cycle completion window that follows an accepted write.

Top module: `xmr_cmd_decode`

## Requirements
- R1: A write is decoded when cs_ni, ras_ni, cas_ni and we_ni are all sampled low and ba_i[0] is sampled high. When the same strobes are low and ba_i[0] is low, the command targets the ordinary mode register, and it changes no output and sets no flag.
- R2: An accepted write loads the register at the clock edge where it is sampled, and the new values show on the outputs in the following cycle. dll_en_o is the inverse of addr_i[0], so 0 means enabled. drive_o is {addr_i[6], addr_i[1]}.
- R3: A write sampled while cke_i is low, or while any bit of bank_idle_i is 0, leaves dll_en_o, drive_o and valid_o unchanged and sets err_state_o.
- R4: drive_o code 2'b01 (weak, about 60 %) and code 2'b11 (matched impedance) are legal. A write that carries code 2'b00 or 2'b10 is rejected and sets err_code_o.
- R5: After an accepted write, busy_o is high for exactly two cycles and then falls.
- R6: A command is any sampled cycle in which cs_ni is low and ras_ni, cas_ni and we_ni are not all high. A command sampled while busy_o is high is not executed and sets err_timing_o. A write sampled in the first cycle after busy_o falls is accepted.
- R7: ba_i[1] and the address bits A2..A5 and A7 up to the top bit are reserved. A write with any of them at 1 is rejected and sets err_rsvd_o.
- R8: valid_o is low after reset and stays low until the first accepted write. After that, the register can be rewritten any number of times.
- R9: rst_ni low clears valid_o, busy_o and all four error flags asynchronously. It leaves the stored dll_en_o and drive_o values untouched.
- R10: Error flags stay set until rst_ni goes low, or until err_clr_i is sampled high at a clock edge where no new error is raised.
- R11: A cycle with cs_ni high is a deselect. It is ignored whatever the other strobes, bank bits and address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable as sampled by the device |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| ba_i | input | 2 | Bank address; bit 0 selects the extended register, bit 1 reserved |
| addr_i | input | ADDR_W (11) | Address lines carrying the register fields |
| bank_idle_i | input | NBANK (4) | One bit per bank, 1 = precharged and idle |
| err_clr_i | input | 1 | Synchronous clear of the sticky error flags |
| dll_en_o | output | 1 | DLL enable, 1 = enabled; valid only when valid_o is high |
| drive_o | output | 2 | Drive strength code {A6, A1} |
| valid_o | output | 1 | Register holds a written value |
| busy_o | output | 1 | Completion window after a write |
| err_state_o | output | 1 | Write attempted with CKE low or a bank not idle |
| err_code_o | output | 1 | Write carried a forbidden drive code |
| err_rsvd_o | output | 1 | Write carried a nonzero reserved bit |
| err_timing_o | output | 1 | Command issued during the completion window |

## Verification
If the legality gate is wrong, the fault shows one cycle after the offending write. Either drive_o or dll_en_o takes a value that should have been rejected, or the matching error flag fails to rise. If the completion counter is off, busy_o falls one cycle early or late. A boundary write placed right at the end of the window then gets the wrong verdict, so a count error is visible within three cycles of the write. If the sticky or reset behaviour is broken, an error flag drops with no clear pulse, or the fields are lost across a reset. The bench reads these back on the very next sample.

// File: rtl/xmr_pkg.sv
package xmr_pkg;
  localparam int DLL_BIT    = 0;
  localparam int DRV_LO_BIT = 1;
  localparam int DRV_HI_BIT = 6;

  typedef enum logic [1:0] {
    DRV_NA0     = 2'b00,
    DRV_WEAK    = 2'b01,
    DRV_NA2     = 2'b10,
    DRV_MATCHED = 2'b11
  } drv_e;

  typedef struct packed {
    logic dll_en;
    drv_e drv;
  } xmr_fields_t;
endpackage

// File: rtl/xmr_cmd_detect.sv
module xmr_cmd_detect (
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic ba_sel_i,
  output logic emr_hit_o,
  output logic cmd_o
);
  logic all_low;
  assign all_low   = ~cs_ni & ~ras_ni & ~cas_ni & ~we_ni;
  // ba_sel low with the same strobes addresses the ordinary mode register
  assign emr_hit_o = all_low & ba_sel_i;
  assign cmd_o     = ~cs_ni & ~(ras_ni & cas_ni & we_ni);
endmodule

// File: rtl/xmr_field_check.sv
module xmr_field_check
  import xmr_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int NBANK  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ba_hi_i,
  input  logic              cke_i,
  input  logic [NBANK-1:0]  bank_idle_i,
  output xmr_fields_t       fields_o,
  output logic              state_bad_o,
  output logic              code_bad_o,
  output logic              rsvd_bad_o
);
  localparam logic [ADDR_W-1:0] KEEP_MASK =
    ADDR_W'((1 << DLL_BIT) | (1 << DRV_LO_BIT) | (1 << DRV_HI_BIT));

  logic [ADDR_W-1:0] rsvd_bits;

  for (genvar g = 0; g < ADDR_W; g++) begin : g_rsvd
    if (KEEP_MASK[g]) begin : g_keep
      assign rsvd_bits[g] = 1'b0;
    end else begin : g_chk
      assign rsvd_bits[g] = addr_i[g];
    end
  end

  assign fields_o.dll_en = ~addr_i[DLL_BIT];
  assign fields_o.drv    = drv_e'({addr_i[DRV_HI_BIT], addr_i[DRV_LO_BIT]});

  assign state_bad_o = ~cke_i | ~(&bank_idle_i);
  // legal codes both have the low bit set
  assign code_bad_o  = ~addr_i[DRV_LO_BIT];
  assign rsvd_bad_o  = ba_hi_i | (|rsvd_bits);
endmodule

// File: rtl/xmr_busy_timer.sv
module xmr_busy_timer #(
  parameter int WRITE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WRITE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(WRITE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/xmr_cmd_decode.sv
module xmr_cmd_decode
  import xmr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int NBANK     = 4,
  parameter int WRITE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [1:0]        ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBANK-1:0]  bank_idle_i,
  input  logic              err_clr_i,
  output logic              dll_en_o,
  output logic [1:0]        drive_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              err_state_o,
  output logic              err_code_o,
  output logic              err_rsvd_o,
  output logic              err_timing_o
);
  logic        emr_hit, any_cmd;
  logic        state_bad, code_bad, rsvd_bad;
  logic        busy, accept;
  logic        set_state, set_code, set_rsvd, set_timing;
  xmr_fields_t fields_new, fields_q;

  xmr_cmd_detect u_detect (
    .cs_ni    (cs_ni),
    .ras_ni   (ras_ni),
    .cas_ni   (cas_ni),
    .we_ni    (we_ni),
    .ba_sel_i (ba_i[0]),
    .emr_hit_o(emr_hit),
    .cmd_o    (any_cmd)
  );

  xmr_field_check #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_check (
    .addr_i     (addr_i),
    .ba_hi_i    (ba_i[1]),
    .cke_i      (cke_i),
    .bank_idle_i(bank_idle_i),
    .fields_o   (fields_new),
    .state_bad_o(state_bad),
    .code_bad_o (code_bad),
    .rsvd_bad_o (rsvd_bad)
  );

  xmr_busy_timer #(.WRITE_CYC(WRITE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .busy_o (busy)
  );

  // a write during the completion window is only a timing fault
  assign set_timing = any_cmd & busy;
  assign set_state  = emr_hit & ~busy & state_bad;
  assign set_code   = emr_hit & ~busy & code_bad;
  assign set_rsvd   = emr_hit & ~busy & rsvd_bad;
  assign accept     = emr_hit & ~busy & ~state_bad & ~code_bad & ~rsvd_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      err_state_o  <= 1'b0;
      err_code_o   <= 1'b0;
      err_rsvd_o   <= 1'b0;
      err_timing_o <= 1'b0;
    end else begin
      if (accept) valid_o <= 1'b1;
      err_state_o  <= set_state  | (err_state_o  & ~err_clr_i);
      err_code_o   <= set_code   | (err_code_o   & ~err_clr_i);
      err_rsvd_o   <= set_rsvd   | (err_rsvd_o   & ~err_clr_i);
      err_timing_o <= set_timing | (err_timing_o & ~err_clr_i);
    end
  end

  // contents are undefined until written, so no reset here
  always_ff @(posedge clk_i) begin
    if (accept) fields_q <= fields_new;
  end

  assign dll_en_o = fields_q.dll_en;
  assign drive_o  = fields_q.drv;
  assign busy_o   = busy;
endmodule

// File: rtl/xmr_cmd_decode_chk.sv
module xmr_cmd_decode_chk #(
  parameter int ADDR_W    = 11,
  parameter int NBANK     = 4,
  parameter int WRITE_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_i,
  input logic              cs_ni,
  input logic              ras_ni,
  input logic              cas_ni,
  input logic              we_ni,
  input logic [1:0]        ba_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NBANK-1:0]  bank_idle_i,
  input logic              err_clr_i,
  input logic              dll_en_o,
  input logic [1:0]        drive_o,
  input logic              valid_o,
  input logic              busy_o,
  input logic              err_state_o,
  input logic              err_code_o,
  input logic              err_rsvd_o,
  input logic              err_timing_o
);
  logic hit, cmd, rsvd, ok, go;
  assign hit  = !cs_ni && !ras_ni && !cas_ni && !we_ni && ba_i[0];
  assign cmd  = !cs_ni && !(ras_ni && cas_ni && we_ni);
  assign rsvd = ba_i[1] || (|addr_i[ADDR_W-1:7]) || (|addr_i[5:2]);
  assign ok   = cke_i && (&bank_idle_i) && !rsvd && addr_i[1];
  assign go   = hit && ok && !busy_o;

  a_r2_fields_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> valid_o && (dll_en_o == !$past(addr_i[0]))
           && (drive_o == {$past(addr_i[6]), $past(addr_i[1])}));

  a_r3_state_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !busy_o && (!cke_i || !(&bank_idle_i)) |=> err_state_o);

  a_r4_code_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !busy_o && !addr_i[1] |=> err_code_o);

  a_r5_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> busy_o);

  a_r5_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  a_r6_timing_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd && busy_o |=> err_timing_o && (drive_o == $past(drive_o))
                      && (dll_en_o == $past(dll_en_o)));

  a_r7_rsvd_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !busy_o && rsvd |=> err_rsvd_o);

  a_r8_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !go |=> !valid_o);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_state_o || err_code_o || err_rsvd_o || err_timing_o) && !err_clr_i
    |=> $countones({err_state_o, err_code_o, err_rsvd_o, err_timing_o}) >=
        $countones($past({err_state_o, err_code_o, err_rsvd_o, err_timing_o})));

  a_r11_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && !err_clr_i |=>
      $stable({valid_o, err_state_o, err_code_o, err_rsvd_o, err_timing_o}));
endmodule

bind xmr_cmd_decode xmr_cmd_decode_chk #(
  .ADDR_W(ADDR_W), .NBANK(NBANK), .WRITE_CYC(WRITE_CYC)
) u_chk (.*);

// File: tb/xmr_cmd_decode_tb.sv
module xmr_cmd_decode_tb_top;
  localparam int ADDR_W = 11;
  localparam int NBANK  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, clr;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;
  logic [NBANK-1:0] idle;
  logic dll_en, valid, busy, e_state, e_code, e_rsvd, e_timing;
  logic [1:0] drive;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  xmr_cmd_decode dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .bank_idle_i(idle),
    .err_clr_i(clr), .dll_en_o(dll_en), .drive_o(drive), .valid_o(valid),
    .busy_o(busy), .err_state_o(e_state), .err_code_o(e_code),
    .err_rsvd_o(e_rsvd), .err_timing_o(e_timing)
  );

  // errors packed as {timing, rsvd, code, state}
  typedef struct packed {
    logic [1:0]  ba;
    logic [10:0] addr;
    logic [3:0]  idle;
    logic        cke;
    logic        acc;
    logic        dll;
    logic [1:0]  drv;
    logic [3:0]  err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 11'h042, 4'hF, 1'b1, 1'b1, 1'b1, 2'b11, 4'b0000}, // R2 matched, dll on
    '{2'b01, 11'h003, 4'hF, 1'b1, 1'b1, 1'b0, 2'b01, 4'b0000}, // R2 weak, dll off
    '{2'b01, 11'h040, 4'hF, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0001 << 1}, // R4 code 10
    '{2'b01, 11'h000, 4'hF, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0010}, // R4 code 00
    '{2'b01, 11'h046, 4'hF, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0100}, // R7 A2
    '{2'b11, 11'h042, 4'hF, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0100}, // R7 BA1
    '{2'b01, 11'h042, 4'hB, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0001}, // R3 bank busy
    '{2'b01, 11'h042, 4'hF, 1'b0, 1'b0, 1'b0, 2'b01, 4'b0001}, // R3 cke low
    '{2'b00, 11'h042, 4'hF, 1'b1, 1'b0, 1'b0, 2'b01, 4'b0000}, // R1 mode reg
    '{2'b01, 11'h042, 4'hF, 1'b1, 1'b1, 1'b1, 2'b11, 4'b0000}, // R8 rewrite
    '{2'b01, 11'h403, 4'hF, 1'b1, 1'b0, 1'b1, 2'b11, 4'b0100}  // R7 A10
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic nop();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    ba = 2'b00; addr = '0; cke = 1'b1; idle = '1;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive for one sampling edge, then return to NOP
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic [ADDR_W-1:0] a);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a;
    @(negedge clk);
    nop();
  endtask

  task automatic clear_err();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  function automatic logic [7:0] errs();
    return {4'h0, e_timing, e_rsvd, e_code, e_state};
  endfunction

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    nop();
    clr = 1'b0;
    step(3);
    chk("R9 reset valid", {7'd0, valid}, 8'd0);
    chk("R9 reset busy", {7'd0, busy}, 8'd0);
    chk("R9 reset errors", errs(), 8'd0);
    rst_ni = 1'b1;
    step(2);

    // R8: a rejected write before the first legal one keeps valid low
    issue(0, 0, 0, 0, 2'b01, 11'h000);
    chk("R8 valid before first write", {7'd0, valid}, 8'd0);
    chk("R4 code 00 flagged", errs(), 8'h02);
    clear_err();

    for (int v = 0; v < NV; v++) begin
      step(2);
      clear_err();
      cke = VECS[v].cke; idle = VECS[v].idle;
      issue(0, 0, 0, 0, VECS[v].ba, VECS[v].addr);
      chk($sformatf("R1/R2 vec%0d valid", v), {7'd0, valid}, 8'd1);
      chk($sformatf("R2 vec%0d dll", v), {7'd0, dll_en}, {7'd0, VECS[v].dll});
      chk($sformatf("R2 vec%0d drive", v), {6'd0, drive}, {6'd0, VECS[v].drv});
      chk($sformatf("R3/R4/R7 vec%0d errors", v), errs(), {4'h0, VECS[v].err});
      chk($sformatf("R5 vec%0d busy 1st", v), {7'd0, busy}, {7'd0, VECS[v].acc});
      step(1);
      chk($sformatf("R5 vec%0d busy 2nd", v), {7'd0, busy}, {7'd0, VECS[v].acc});
      step(1);
      chk($sformatf("R5 vec%0d busy end", v), {7'd0, busy}, 8'd0);
    end

    // R6: commands inside the window are dropped and flagged
    step(2);
    clear_err();
    issue(0, 0, 0, 0, 2'b01, 11'h003);
    issue(0, 0, 0, 0, 2'b01, 11'h042);
    chk("R6 write in window flagged", errs(), 8'h08);
    chk("R6 write in window dropped", {6'd0, drive}, 8'h01);
    chk("R6 write in window dll kept", {7'd0, dll_en}, 8'd0);
    issue(0, 1, 0, 1, 2'b00, 11'h000);
    chk("R5 busy low after two cycles", {7'd0, busy}, 8'd0);
    clear_err();
    chk("R10 clear pulse", errs(), 8'h00);

    // R6 boundary: write right after the window closes is accepted
    issue(0, 0, 0, 0, 2'b01, 11'h003);
    step(2);
    issue(0, 0, 0, 0, 2'b01, 11'h042);
    chk("R6 boundary write accepted", {6'd0, drive}, 8'h03);
    chk("R6 boundary no timing error", errs(), 8'h00);
    step(2);

    // R11: deselect with all other strobes low is ignored
    issue(1, 0, 0, 0, 2'b01, 11'h003);
    chk("R11 deselect drive", {6'd0, drive}, 8'h03);
    chk("R11 deselect dll", {7'd0, dll_en}, 8'd1);
    chk("R11 deselect busy", {7'd0, busy}, 8'd0);
    chk("R11 deselect errors", errs(), 8'h00);

    // R10: sticky across idle cycles
    issue(0, 0, 0, 0, 2'b01, 11'h004);
    step(5);
    chk("R10 sticky rsvd", errs(), 8'h06);

    // R9: reset clears flags, keeps fields
    rst_ni = 1'b0;
    step(1);
    rst_ni = 1'b1;
    step(1);
    chk("R9 flags cleared", errs(), 8'h00);
    chk("R9 valid cleared", {7'd0, valid}, 8'd0);
    chk("R9 drive kept", {6'd0, drive}, 8'h03);
    chk("R9 dll kept", {7'd0, dll_en}, 8'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule